// File: doc/BRIEF.md
# DMA Request Router and Interrupt Aggregator

This block sits between the peripherals and a bank of DMA channel engines. Each peripheral request line has its own mapping register. When the mapping is marked valid, the request is steered onto the flow-control input of the channel that the mapping names. Several sources may name the same channel, and that channel's request is then the OR of all of them. Clearing a mapping register disconnects its peripheral from every channel.

The block also collects the per-channel interrupt lines into one summary register, with one bit per channel. Any set bit drives a single interrupt output. Software reads the summary to learn which channels need service. It acknowledges them by writing the value it read back to the same offset: each 1 clears the matching bit, unless that channel's interrupt line is still high.

Top module: `dma_req_router`

## Requirements
- R1: After reset every mapping register reads 0, the summary reads 0, `irq_out` is 0, and `chan_req` is 0 whatever `periph_req` carries.
- R2: Mapping register i sits at byte offset 0x100 + 4*i (i = 0..39). Bit 7 is the valid flag and bits 3:0 the target channel. A read returns exactly those bits as last written, and every other bit reads 0.
- R3: `chan_req[c]` is the OR of `periph_req[i]` over every i whose mapping is valid and names channel c. It is combinational, in the same cycle.
- R4: A mapping with bit 7 clear contributes to no channel, whatever its channel bits hold. This includes the all-zero value.
- R5: A summary bit c is set at each clock edge where `chan_irq[c]` is high. It then stays set until software acknowledges it.
- R6: A write to offset 0xF0 clears, at that edge, every summary bit written as 1 whose interrupt input is low at that edge. Bits written as 0 are left unchanged, and a bit whose input is still high stays set.
- R7: `irq_out` is high exactly when at least one summary bit is set.
- R8: Reads of any offset other than 0xF0 and the 40 mapping registers return 0. Writes there change no state.
- R9: The summary register at 0xF0 reads back its current bits, with channel c at bit c. Writing 1 to a clear summary bit does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wen | input | 1 | Write strobe, taken at the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| periph_req | input | 40 | Peripheral DMA request lines |
| chan_req | output | 16 | Routed request to each channel's flow-control input |
| chan_irq | input | 16 | Interrupt line from each channel |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
The bench builds the block with its default parameters: 40 request sources and 16 channels. With these values every channel number from 0 to 15 and the highest mapping register at 0x19C are within reach. The offset at 0x1A0, one past the last mapping register, is also reachable, so the boundary of the decode is exercised. Random mappings, including ones whose channel bits are set while the valid flag is clear, let many sources fold onto one channel. Random interrupt patterns mixed with acknowledge writes show the set-over-clear priority and the rule that a write cannot set a summary bit.

// File: rtl/dma_req_router.sv
module dma_req_router #(
  parameter int NUM_REQ  = 40,
  parameter int NUM_CH   = 16,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int MAP_BASE = 'h100,
  parameter int SUM_ADDR = 'h0F0,
  parameter int VALID_BIT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        reg_addr,
  input  logic               reg_wen,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [39:0]        periph_req,
  output logic [15:0]        chan_req,
  input  logic [15:0]        chan_irq,
  output logic               irq_out
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int IDX_W = $clog2(NUM_REQ);
  localparam logic [ADDR_W-1:0] BASE_WORD = ADDR_W'(MAP_BASE / 4);
  localparam logic [ADDR_W-1:0] END_WORD  = ADDR_W'(MAP_BASE / 4 + NUM_REQ);
  localparam logic [ADDR_W-1:0] SUM_WORD  = ADDR_W'(SUM_ADDR / 4);

  logic [NUM_REQ-1:0] map_v;
  logic [CH_W-1:0]    map_ch [NUM_REQ];
  logic [NUM_CH-1:0]  sum;

  logic [ADDR_W-1:0] word, map_off;
  logic [IDX_W-1:0]  map_sel;
  logic              map_hit, sum_hit;
  logic [NUM_CH-1:0] ack;

  assign word    = {2'b00, reg_addr[ADDR_W-1:2]};
  assign map_hit = (word >= BASE_WORD) && (word < END_WORD);
  assign sum_hit = (word == SUM_WORD);
  assign map_off = word - BASE_WORD;
  assign map_sel = map_off[IDX_W-1:0];
  assign ack     = (reg_wen && sum_hit) ? reg_wdata[NUM_CH-1:0] : '0;
  assign irq_out = |sum;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_v[i]  <= 1'b0;
        map_ch[i] <= '0;
      end else if (reg_wen && map_hit && map_sel == IDX_W'(i)) begin
        map_v[i]  <= reg_wdata[VALID_BIT];
        map_ch[i] <= reg_wdata[CH_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum <= '0;
    else        sum <= (sum & ~ack) | chan_irq;
  end

  always_comb begin
    chan_req = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int i = 0; i < NUM_REQ; i++)
        if (map_v[i] && map_ch[i] == CH_W'(c) && periph_req[i])
          chan_req[c] = 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    if (sum_hit) begin
      reg_rdata[NUM_CH-1:0] = sum;
    end else if (map_hit) begin
      reg_rdata[VALID_BIT]  = map_v[map_sel];
      reg_rdata[CH_W-1:0]   = map_ch[map_sel];
    end
  end

  // Summary bits capture every interrupt seen at the previous edge.
  assert_sum_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sum & $past(chan_irq)) == $past(chan_irq)));

  // A summary bit falls only when acknowledged.
  assert_sum_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sum) & ~sum) & ~$past(ack)) == '0));

  // An acknowledged bit with a quiet input is gone after the edge.
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sum & $past(ack) & ~$past(chan_irq)) == '0));

  // The interrupt output only rises after some channel raised its line.
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(|chan_irq));

  // With no valid mapping, no channel sees a request.
  assert_no_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (map_v == '0) |-> (chan_req == '0));
endmodule

// File: tb/dma_req_router_test.sv
module dma_req_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [39:0] periph_req = '0;
  logic [15:0] chan_req;
  logic [15:0] chan_irq = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0]  m_map [40];
  logic [15:0] m_sum = '0;

  dma_req_router uut (.*);

  always #2 clk = ~clk;

  function automatic logic [15:0] exp_route(logic [39:0] r);
    logic [15:0] o = '0;
    for (int i = 0; i < 40; i++)
      if (m_map[i][7] && r[i]) o[m_map[i][3:0]] = 1'b1;
    return o;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(posedge clk);
    #1 reg_wen = 1'b0;
    if (a >= 12'h100 && a < 12'h1A0) m_map[(a - 12'h100) >> 2] = {d[7], 3'b000, d[3:0]};
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic irq_step(logic [15:0] irq, logic do_ack, logic [15:0] ackv);
    @(negedge clk);
    reg_addr = 12'h0F0; chan_irq = irq; reg_wen = do_ack; reg_wdata = {16'hA5A5, ackv};
    @(posedge clk);
    m_sum = (m_sum & ~(do_ack ? ackv : 16'h0)) | irq;
    #1 reg_wen = 1'b0;
    check("R5/R6/R9 summary", {16'h0, reg_rdata[15:0]}, {16'h0, m_sum});
    check("R7 irq_out", {31'h0, irq_out}, {31'h0, m_sum != 0});
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd7719));
    for (int i = 0; i < 40; i++) m_map[i] = '0;
    periph_req = {$urandom, $urandom};
    #1;
    check("R1 chan_req in reset", {16'h0, chan_req}, 32'h0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(12'h0F0, d); check("R1 summary", d, 32'h0);
    check("R1 irq_out", {31'h0, irq_out}, 32'h0);
    for (int i = 0; i < 40; i++) begin
      rd(12'h100 + 12'(i * 4), d); check("R1 map reset", d, 32'h0);
    end
    periph_req = '1; #1;
    check("R1/R4 no route after reset", {16'h0, chan_req}, 32'h0);

    wr(12'h100, 32'hFFFF_FF8A);
    rd(12'h100, d); check("R2 readback masks", d, 32'h0000_008A);
    wr(12'h19C, 32'h0000_008F);
    rd(12'h19C, d); check("R2 last map", d, 32'h0000_008F);
    periph_req = 40'h80_0000_0001; #1;
    check("R3 two sources", {16'h0, chan_req}, 32'h0000_8400);
    wr(12'h100, 32'h0000_000A);
    periph_req = 40'h00_0000_0001; #1;
    check("R4 invalid with channel bits", {16'h0, chan_req}, 32'h0);

    for (int k = 0; k < 400; k++) begin
      int idx = $urandom_range(0, 39);
      logic [31:0] v = $urandom;
      if ($urandom_range(0, 3) == 0) v[7] = 1'b0;
      wr(12'h100 + 12'(idx * 4), v);
      rd(12'h100 + 12'($urandom_range(0, 39) * 4), d);
      check("R2 random readback", d, {24'h0, m_map[(reg_addr - 12'h100) >> 2]});
      for (int j = 0; j < 3; j++) begin
        periph_req = {$urandom, $urandom};
        if (j == 0) periph_req = 40'(1) << $urandom_range(0, 39);
        #1 check("R3/R4 random route", {16'h0, chan_req}, {16'h0, exp_route(periph_req)});
      end
    end
    wr(12'h100, 32'h0);
    periph_req = 40'h1; #1;
    check("R4 cleared map", {16'h0, chan_req}, {16'h0, exp_route(periph_req)});

    irq_step(16'h0000, 1'b1, 16'hFFFF);
    irq_step(16'h0009, 1'b0, 16'h0);
    irq_step(16'h0000, 1'b0, 16'h0);
    irq_step(16'h0000, 1'b1, 16'h0001);
    irq_step(16'h0008, 1'b1, 16'h0008);
    irq_step(16'h0000, 1'b1, 16'h0008);
    irq_step(16'h0000, 1'b1, 16'hFFFF);
    for (int k = 0; k < 600; k++) begin
      logic [15:0] irq = 16'($urandom) & 16'($urandom) & 16'($urandom);
      logic [15:0] av = ($urandom_range(0, 1) == 1) ? m_sum : 16'($urandom);
      irq_step(irq, $urandom_range(0, 2) != 0, av);
    end
    irq_step(16'h0000, 1'b1, 16'hFFFF);
    irq_step(16'h8000, 1'b0, 16'h0);
    chan_irq = '0;

    rd(12'h000, d); check("R8 offset 0x000", d, 32'h0);
    rd(12'h0F4, d); check("R8 offset 0x0F4", d, 32'h0);
    rd(12'h1A0, d); check("R8 offset 0x1A0", d, 32'h0);
    rd(12'hFFC, d); check("R8 offset 0xFFC", d, 32'h0);
    wr(12'h1A0, 32'hFFFF_FFFF);
    wr(12'h0F8, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    for (int i = 0; i < 40; i++) begin
      rd(12'h100 + 12'(i * 4), d); check("R8 maps untouched", d, {24'h0, m_map[i]});
    end
    rd(12'h0F0, d); check("R8 summary untouched", d, {16'h0, m_sum});
    check("R7 irq_out held", {31'h0, irq_out}, 32'h1);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule